// File: doc/BRIEF.md
# Interrupt-Capable GPIO Bank

This block is one 32-pin general purpose I/O bank. It has a memory-mapped register port that takes one read or one write per cycle. It drives the pad output values and the per-pin output enables. It samples the pad inputs through a synchronizer. It raises a single interrupt line for the whole bank.

Each pin can watch for a level or for an edge, with a polarity chosen per pin. A detected condition sets a sticky status bit. That bit is latched only when the pin is enabled as an interrupt source. The interrupt line is driven only by status bits whose separate forwarding enable is also set.

Every register has three addresses:

- The row base, where a write replaces the whole register.
- Base plus 4, where each written 1 sets the matching bit.
- Base plus 8, where each written 1 clears the matching bit.

Register rows sit at fixed bases plus `BANK_ID`×0x10:

| Register | Base |
|---|---|
| output data | 0x0700 |
| input level (read only) | 0x0900 |
| output enable | 0x0B00 |
| source enable | 0x1000 |
| forwarding enable | 0x1100 |
| detection kind | 0x1200 |
| polarity | 0x1300 |
| status | 0x1400 |

The register port never stalls, so it has no back-pressure. A write is accepted in the cycle where `bus_wr_en` is high. A read request is taken in the cycle where `bus_rd_en` is high, and its data appears with `bus_rvalid` one cycle later. The reader must accept that data in that cycle. When a read and a write arrive together, the read returns the value from before the write.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the output enable, source enable, forwarding enable and status registers read as zero, `pad_oe` is zero and `irq` is low.
- R2: A write to a register's base address replaces all 32 bits. `pad_out` and `pad_oe` follow the output data and output enable registers.
- R3: A write to base+4 sets exactly the bits written as 1 and leaves every other bit unchanged.
- R4: A write to base+8 clears exactly the bits written as 1. For status, writing all ones to base+8 clears every pending bit.
- R5: `pad_in` passes through two flops before it is visible. A read of the input level register returns the pad level from two clock edges earlier.
- R6: Detection kind bit 0 selects edge detection. With polarity bit 1, a rising edge on the synchronized input sets the status bit, and a falling edge does not.
- R7: In edge detection with polarity bit 0, a falling edge sets the status bit, and a rising edge does not.
- R8: Detection kind bit 1 selects level detection. The status bit is set in every cycle while the input equals the polarity bit (1 means high, 0 means low). The 2-bit type {polarity, kind} is therefore 0 falling, 1 low, 2 rising, 3 high.
- R9: A pin whose source enable bit is 0 never sets its status bit.
- R10: `irq` is high exactly when some bit is set in both status and forwarding enable. Clearing a forwarding enable bit drops `irq` but keeps the status bit.
- R11: Plain writes and set-alias writes to the status register are ignored.
- R12: When a new detection and a status clear hit the same bit in the same cycle, the bit ends up set.
- R13: The bank answers only at its own row addresses, which are offset by `BANK_ID`×0x10. A read of any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_en | input | 1 | Write strobe, one per cycle |
| bus_rd_en | input | 1 | Read request |
| bus_addr | input | 16 | Byte address for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | High one cycle after a read request |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables, 1 means drive |
| irq | output | 1 | Combined bank interrupt |

## Verification
The detectors are exercised with one pin set up for each of the four types. The same pad transitions are applied to pins of different types, so the result shows whether each pin responds only to the transition its type selects. A level pin is held active while its status bit is cleared. This tells re-assertion and the set-over-clear priority apart from a plain edge latch. Register tests use patterns whose set and clear masks overlap bits that are already set and bits that are not, and then compare reads at the base row, at the alias rows and at a foreign bank row.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int NUM_CFG = 6;
  localparam int ROW_STRIDE = 16;

  localparam int IDX_DOUT = 0;
  localparam int IDX_DOE  = 1;
  localparam int IDX_SRC  = 2;
  localparam int IDX_FWD  = 3;
  localparam int IDX_KIND = 4;
  localparam int IDX_POL  = 5;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_PLAIN,
    ACC_SET,
    ACC_CLR
  } acc_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DOUT,
    SEL_DIN,
    SEL_DOE,
    SEL_SRC,
    SEL_FWD,
    SEL_KIND,
    SEL_POL,
    SEL_STAT
  } sel_e;

  function automatic logic [15:0] row_base(sel_e s);
    case (s)
      SEL_DOUT: row_base = 16'h0700;
      SEL_DIN:  row_base = 16'h0900;
      SEL_DOE:  row_base = 16'h0B00;
      SEL_SRC:  row_base = 16'h1000;
      SEL_FWD:  row_base = 16'h1100;
      SEL_KIND: row_base = 16'h1200;
      SEL_POL:  row_base = 16'h1300;
      SEL_STAT: row_base = 16'h1400;
      default:  row_base = 16'hFFF0;
    endcase
  endfunction

  function automatic sel_e cfg_sel(int idx);
    case (idx)
      IDX_DOUT: cfg_sel = SEL_DOUT;
      IDX_DOE:  cfg_sel = SEL_DOE;
      IDX_SRC:  cfg_sel = SEL_SRC;
      IDX_FWD:  cfg_sel = SEL_FWD;
      IDX_KIND: cfg_sel = SEL_KIND;
      IDX_POL:  cfg_sel = SEL_POL;
      default:  cfg_sel = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int AW      = 16,
  parameter int BANK_ID = 0
) (
  input  logic [AW-1:0] addr,
  output sel_e          sel,
  output acc_e          acc
);

  logic [AW-1:0] row;
  acc_e          acc_raw;
  sel_e          sel_raw;

  assign row = {addr[AW-1:4], 4'b0000};

  always_comb begin
    case (addr[3:0])
      4'h0:    acc_raw = ACC_PLAIN;
      4'h4:    acc_raw = ACC_SET;
      4'h8:    acc_raw = ACC_CLR;
      default: acc_raw = ACC_NONE;
    endcase
  end

  always_comb begin
    sel_raw = SEL_NONE;
    for (int k = 1; k <= 8; k++) begin
      if (row == AW'(32'(row_base(sel_e'(4'(k)))) + 32'(BANK_ID * ROW_STRIDE)))
        sel_raw = sel_e'(4'(k));
    end
  end

  always_comb begin
    if (acc_raw == ACC_NONE || sel_raw == SEL_NONE) begin
      sel = SEL_NONE;
      acc = ACC_NONE;
    end else begin
      sel = sel_raw;
      acc = acc_raw;
    end
  end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_bank_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  acc_e         acc,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (hit) begin
      case (acc)
        ACC_PLAIN: q <= wdata;
        ACC_SET:   q <= q | wdata;
        ACC_CLR:   q <= q & ~wdata;
        default:   q <= q;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] src_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] prev_q;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall;
    assign rise   = din[i] & ~prev_q[i];
    assign fall   = ~din[i] & prev_q[i];
    assign hit[i] = kind[i] ? (din[i] == pol[i]) : (pol[i] ? rise : fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= din;
      stat_q <= (stat_q & ~clr_mask) | (hit & src_en);
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int W           = 32,
  parameter int AW          = 16,
  parameter int BANK_ID     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_en,
  input  logic          bus_rd_en,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  output logic          bus_rvalid,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic          irq
);

  sel_e         sel;
  acc_e         acc;
  logic [W-1:0] cfg_q [NUM_CFG];
  logic [W-1:0] din_s;
  logic [W-1:0] stat_q;
  logic [W-1:0] clr_mask;
  logic [W-1:0] p2i_q;
  logic [W-1:0] ien_q;
  logic [W-1:0] rd_mux;

  gpio_addr_decode #(.AW(AW), .BANK_ID(BANK_ID)) u_dec (
    .addr(bus_addr),
    .sel (sel),
    .acc (acc)
  );

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam sel_e MY_SEL = cfg_sel(g);
    gpio_alias_reg #(.W(W)) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .hit  (bus_wr_en && (sel == MY_SEL)),
      .acc  (acc),
      .wdata(bus_wdata),
      .q    (cfg_q[g])
    );
  end

  gpio_pin_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (din_s)
  );

  assign clr_mask = (bus_wr_en && sel == SEL_STAT && acc == ACC_CLR) ? bus_wdata : '0;

  gpio_irq_detect #(.W(W)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din_s),
    .kind    (cfg_q[IDX_KIND]),
    .pol     (cfg_q[IDX_POL]),
    .src_en  (cfg_q[IDX_SRC]),
    .clr_mask(clr_mask),
    .stat_q  (stat_q)
  );

  assign p2i_q   = cfg_q[IDX_SRC];
  assign ien_q   = cfg_q[IDX_FWD];
  assign pad_out = cfg_q[IDX_DOUT];
  assign pad_oe  = cfg_q[IDX_DOE];
  assign irq     = |(stat_q & ien_q);

  always_comb begin
    rd_mux = '0;
    if (sel == SEL_DIN)  rd_mux = din_s;
    if (sel == SEL_STAT) rd_mux = stat_q;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (sel == cfg_sel(k)) rd_mux = cfg_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int W       = 32,
  parameter int AW      = 16,
  parameter int BANK_ID = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr_en,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  stat_q,
  input logic [W-1:0]  p2i_q,
  input logic [W-1:0]  ien_q,
  input logic [W-1:0]  pad_oe,
  input logic          irq
);

  localparam logic [AW-1:0] STAT_CLR_ADDR = AW'(32'h1408 + BANK_ID * 16);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (stat_q == '0 && pad_oe == '0));

  // R9
  src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(p2i_q)) == '0));

  // R4
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == STAT_CLR_ADDR) |=> ((stat_q & $past(bus_wdata) & ~$past(p2i_q)) == '0));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0 && stat_q != '0));

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_en |=> $stable(pad_oe));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.W(W), .AW(AW), .BANK_ID(BANK_ID)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr_en(bus_wr_en),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .stat_q   (stat_q),
  .p2i_q    (p2i_q),
  .ien_q    (ien_q),
  .pad_oe   (pad_oe),
  .irq      (irq)
);

// File: tb/gpio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb_top;

  localparam int BANK = 2;
  localparam logic [15:0] A_DOUT = 16'h0700 + BANK*16;
  localparam logic [15:0] A_DIN  = 16'h0900 + BANK*16;
  localparam logic [15:0] A_DOE  = 16'h0B00 + BANK*16;
  localparam logic [15:0] A_SRC  = 16'h1000 + BANK*16;
  localparam logic [15:0] A_FWD  = 16'h1100 + BANK*16;
  localparam logic [15:0] A_KIND = 16'h1200 + BANK*16;
  localparam logic [15:0] A_POL  = 16'h1300 + BANK*16;
  localparam logic [15:0] A_STAT = 16'h1400 + BANK*16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  gpio_irq_bank #(.BANK_ID(BANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected read data as the design returns it
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    bus_read(A_DOE,  32'h0, "R1 doe");
    bus_read(A_SRC,  32'h0, "R1 src");
    bus_read(A_FWD,  32'h0, "R1 fwd");
    bus_read(A_STAT, 32'h0, "R1 stat");

    // R2 plain write
    bus_write(A_DOUT, 32'hA5A5_0F0F);
    bus_read(A_DOUT, 32'hA5A5_0F0F, "R2 dout");
    check("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    bus_write(A_DOE, 32'hFFFF_0000);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    // R3 set alias
    bus_write(A_DOUT + 16'h4, 32'h0000_F00F);
    bus_read(A_DOUT, 32'hA5A5_FF0F, "R3 set");
    // R4 clear alias
    bus_write(A_DOUT + 16'h8, 32'hA500_000F);
    bus_read(A_DOUT, 32'h00A5_FF00, "R4 clr");
    check("R4 pad_out", pad_out, 32'h00A5_FF00);
    // R13 foreign bank row and alias read
    bus_read(16'h0700, 32'h0, "R13 other bank");
    bus_read(A_DOUT + 16'h4, 32'h00A5_FF00, "R13 alias row read");

    // R5 synchronizer delay
    @(negedge clk);
    pad_in = 32'h1234_5678;
    bus_read(A_DIN, 32'h0, "R5 not yet visible");
    settle(2);
    bus_read(A_DIN, 32'h1234_5678, "R5 din");
    @(negedge clk);
    pad_in = 32'h0;
    settle(4);

    // edge setup: pin3 rising, pin5 falling
    bus_write(A_POL,  32'h0000_0008);
    bus_write(A_SRC,  32'h0000_0028);
    bus_write(A_FWD,  32'h0000_0028);
    bus_write(A_STAT + 16'h8, 32'hFFFF_FFFF);
    @(negedge clk);
    pad_in = 32'h0000_0028;
    settle(5);
    // R6 rising latches pin3 only
    bus_read(A_STAT, 32'h0000_0008, "R6 rising");
    check("R10 irq high", {31'h0, irq}, 32'h1);
    // R10 forwarding enable gates irq only
    bus_write(A_FWD + 16'h8, 32'h0000_0008);
    check("R10 irq low", {31'h0, irq}, 32'h0);
    bus_read(A_STAT, 32'h0000_0008, "R10 status kept");
    bus_write(A_FWD + 16'h4, 32'h0000_0008);
    // R4 clear all
    bus_write(A_STAT + 16'h8, 32'hFFFF_FFFF);
    bus_read(A_STAT, 32'h0, "R4 stat clear all");
    // R7 falling latches pin5 only
    @(negedge clk);
    pad_in = 32'h0;
    settle(5);
    bus_read(A_STAT, 32'h0000_0020, "R7 falling");
    // R11 plain and set writes ignored
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_write(A_STAT + 16'h4, 32'hFFFF_FFFF);
    bus_read(A_STAT, 32'h0000_0020, "R11 stat writes ignored");
    bus_write(A_STAT + 16'h8, 32'h0000_0020);
    // R9 pin7 rising but not a source
    bus_write(A_POL + 16'h4, 32'h0000_0080);
    bus_write(A_FWD + 16'h4, 32'h0000_0080);
    @(negedge clk);
    pad_in = 32'h0000_0080;
    settle(5);
    bus_read(A_STAT, 32'h0, "R9 source disabled");
    check("R9 irq", {31'h0, irq}, 32'h0);

    // R8 level high on pin9
    bus_write(A_KIND + 16'h4, 32'h0000_0200);
    bus_write(A_POL + 16'h4, 32'h0000_0200);
    bus_write(A_SRC + 16'h4, 32'h0000_0200);
    bus_write(A_FWD + 16'h4, 32'h0000_0200);
    bus_read(A_STAT, 32'h0, "R8 idle level");
    @(negedge clk);
    pad_in = 32'h0000_0280;
    settle(5);
    bus_read(A_STAT, 32'h0000_0200, "R8 level high");
    // R12 clear while condition holds: bit stays set
    bus_write(A_STAT + 16'h8, 32'h0000_0200);
    bus_read(A_STAT, 32'h0000_0200, "R12 event beats clear");
    @(negedge clk);
    pad_in = 32'h0000_0080;
    settle(5);
    bus_write(A_STAT + 16'h8, 32'h0000_0200);
    bus_read(A_STAT, 32'h0, "R8 level gone");
    // R8 level low
    bus_write(A_POL + 16'h8, 32'h0000_0200);
    settle(2);
    bus_read(A_STAT, 32'h0000_0200, "R8 level low");
    check("R10 irq level", {31'h0, irq}, 32'h1);

    settle(3);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL reads outstanding actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule